// File: doc/BRIEF.md
# Serial Result Readout Port

This block is the slave side of a converter's serial readout. An external master supplies the serial clock. On each pulse the block presents the next bit of a 16-bit frame on a data output that can be switched to high impedance. The frame is four zero bits followed by a 12-bit straight-binary result, most significant bit first. The conversion logic writes the result into a frame register with a one-cycle load strobe.

The whole port runs on a fast system clock. The serial clock and the convert-start line arrive asynchronously, so each is synchronized before its edges are detected. A 5-bit edge counter selects the bit that is driven. The counter returns to the start of the frame only on a falling convert-start edge, and only if the serial clock is low at that moment. After the sixteenth falling edge the output stays driven for a short hold window and is then released. Any further serial clock pulses wrap around to the start of the frame and drive the output again.

Top module: `sdo_port`

## Requirements
- R1: After the asynchronous reset, `sdo_oe_o` is 0 and `sdo_o` is 0. Both stay that way until the first serial clock rising edge.
- R2: The frame is `{4'b0000, result[11:0]}`, indexed 15 down to 0. After falling edge k of a frame (k = 1..15), `sdo_o` shows frame bit 15-k.
- R3: `sdo_oe_o` goes high only on a serial clock rising edge. The first rising edge of a frame drives frame bit 15 (a leading zero).
- R4: A rising edge of the serial clock while the output is enabled leaves `sdo_o` unchanged. Data moves only on falling edges.
- R5: The LSB (frame bit 0, result bit 0) appears after the fifteenth falling edge.
- R6: At the sixteenth falling edge, `sdo_o` keeps the LSB and `sdo_oe_o` stays high for HOLD_CYCLES system cycles. Then `sdo_oe_o` drops and `sdo_o` reads 0.
- R7: After the release, another rising edge enables the output again with frame bit 15. Later falling edges continue through the frame in order, and the output stays enabled after the clock stops.
- R8: A falling edge of convert-start while the serial clock is low disables the output. It also returns the position to the start of the frame, so the next rising edge drives frame bit 15.
- R9: A falling edge of convert-start while the serial clock is high has no effect. The frame position and the output enable are kept.
- R10: The serial clock may pause low for any number of cycles inside a frame. The driven bit and the position are kept across the pause.
- R11: A pulse on `load_i` copies `result_i` into the frame register. Changes on `result_i` without `load_i` do not change the bits shifted out.
- R12: The edge counter is 5 bits wide. At the thirty-second falling edge it wraps to frame bit 15 and does not release the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sclk_i | input | 1 | Serial clock from the master, asynchronous |
| cnv_i | input | 1 | Convert-start, asynchronous; its falling edge resets the port |
| load_i | input | 1 | One-cycle strobe that captures result_i |
| result_i | input | 12 | Parallel conversion result |
| sdo_o | output | 1 | Serial data, 0 when not enabled |
| sdo_oe_o | output | 1 | Output enable for the data line's tri-state driver |

## Verification
The bench walks several result patterns through complete frames. It pauses the serial clock at mid-frame and puts a rising edge between every pair of falling edges. A port that shifted on the wrong edge, or lost its place during a pause, would show the wrong bit. Directed tests cover the following cases, each with the fault it would expose:
- The hold and release at the sixteenth edge: a port that released early would lose the LSB, and one that never released would keep the line driven.
- The wrap past the frame end and across the 5-bit counter overflow: a port that released at the thirty-second edge would drop the output enable.
- A convert-start edge with the serial clock high, which must be ignored: a port that reset anyway would restart mid-frame.
- A result change without the load strobe: a port that passed `result_i` straight through would corrupt a frame already being read.

// File: rtl/sdo_port_pkg.sv
package sdo_port_pkg;
  localparam int unsigned SIG_SCLK = 0;
  localparam int unsigned SIG_CNV  = 1;
  localparam int unsigned SIG_NUM  = 2;
endpackage

// File: rtl/sdo_sync.sv
module sdo_sync #(
  parameter int unsigned NUM    = 2,
  parameter int unsigned STAGES = 2
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [NUM-1:0] async_i,
  output logic [NUM-1:0] lvl_o,
  output logic [NUM-1:0] prev_o
);
  for (genvar g = 0; g < NUM; g++) begin : g_ch
    // STAGES flops for metastability, one more for the previous level
    logic [STAGES:0] chain_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain_q <= '0;
      else         chain_q <= {chain_q[STAGES-1:0], async_i[g]};
    end
    assign lvl_o[g]  = chain_q[STAGES-1];
    assign prev_o[g] = chain_q[STAGES];
  end
endmodule

// File: rtl/sdo_frame_reg.sv
module sdo_frame_reg #(
  parameter int unsigned RES_W      = 12,
  parameter int unsigned LEAD_ZEROS = 4
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        load_i,
  input  logic [RES_W-1:0]            result_i,
  output logic [RES_W+LEAD_ZEROS-1:0] frame_o
);
  localparam int unsigned FRAME_W = RES_W + LEAD_ZEROS;

  logic [RES_W-1:0] res_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     res_q <= '0;
    else if (load_i) res_q <= result_i;
  end

  assign frame_o = FRAME_W'(res_q);
endmodule

// File: rtl/sdo_shift_ctrl.sv
module sdo_shift_ctrl #(
  parameter int unsigned FRAME_W     = 16,
  parameter int unsigned HOLD_CYCLES = 4,
  localparam int unsigned IDX_W      = $clog2(FRAME_W),
  localparam int unsigned CNT_W      = IDX_W + 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [FRAME_W-1:0] frame_i,
  input  logic               sclk_rise_i,
  input  logic               sclk_fall_i,
  input  logic               frame_rst_i,
  output logic               sdo_o,
  output logic               oe_o,
  output logic [CNT_W-1:0]   cnt_o
);
  localparam int unsigned HOLD_W = $clog2(HOLD_CYCLES + 1);

  logic [CNT_W-1:0]  cnt_q, cnt_nxt;
  logic [HOLD_W-1:0] hold_q;
  logic              oe_q, sdo_q, release_evt;

  assign cnt_nxt     = cnt_q + 1'b1;
  assign release_evt = (cnt_nxt == CNT_W'(FRAME_W));

  // FRAME_W is a power of two: bit FRAME_W-1-idx equals bit ~idx
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      hold_q <= '0;
      oe_q   <= 1'b0;
      sdo_q  <= 1'b0;
    end else if (frame_rst_i) begin
      cnt_q  <= '0;
      hold_q <= '0;
      oe_q   <= 1'b0;
      sdo_q  <= 1'b0;
    end else if (sclk_fall_i) begin
      cnt_q <= cnt_nxt;
      if (release_evt) hold_q <= HOLD_W'(HOLD_CYCLES);
      else             sdo_q  <= frame_i[~cnt_nxt[IDX_W-1:0]];
    end else if (sclk_rise_i) begin
      hold_q <= '0;
      if (!oe_q) begin
        oe_q  <= 1'b1;
        sdo_q <= frame_i[~cnt_q[IDX_W-1:0]];
      end
    end else if (hold_q == HOLD_W'(1)) begin
      hold_q <= '0;
      oe_q   <= 1'b0;
    end else if (hold_q != '0) begin
      hold_q <= hold_q - 1'b1;
    end
  end

  assign sdo_o = oe_q & sdo_q;
  assign oe_o  = oe_q;
  assign cnt_o = cnt_q;
endmodule

// File: rtl/sdo_port.sv
module sdo_port #(
  parameter int unsigned RES_W       = 12,
  parameter int unsigned LEAD_ZEROS  = 4,
  parameter int unsigned HOLD_CYCLES = 4,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sclk_i,
  input  logic             cnv_i,
  input  logic             load_i,
  input  logic [RES_W-1:0] result_i,
  output logic             sdo_o,
  output logic             sdo_oe_o
);
  import sdo_port_pkg::*;

  localparam int unsigned FRAME_W = RES_W + LEAD_ZEROS;
  localparam int unsigned CNT_W   = $clog2(FRAME_W) + 1;

  logic [SIG_NUM-1:0] lvl, prev;
  logic [FRAME_W-1:0] frame;
  logic [CNT_W-1:0]   bit_cnt;
  logic               sclk_lvl, sclk_rise, sclk_fall, cnv_fall, frame_rst;

  sdo_sync #(.NUM(SIG_NUM), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .async_i ({cnv_i, sclk_i}),
    .lvl_o   (lvl),
    .prev_o  (prev)
  );

  assign sclk_lvl  = lvl[SIG_SCLK];
  assign sclk_rise = lvl[SIG_SCLK] & ~prev[SIG_SCLK];
  assign sclk_fall = ~lvl[SIG_SCLK] & prev[SIG_SCLK];
  assign cnv_fall  = ~lvl[SIG_CNV] & prev[SIG_CNV];
  // reset qualified by serial clock low
  assign frame_rst = cnv_fall & ~sclk_lvl;

  sdo_frame_reg #(.RES_W(RES_W), .LEAD_ZEROS(LEAD_ZEROS)) u_frame (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (load_i),
    .result_i (result_i),
    .frame_o  (frame)
  );

  sdo_shift_ctrl #(.FRAME_W(FRAME_W), .HOLD_CYCLES(HOLD_CYCLES)) u_shift (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .frame_i     (frame),
    .sclk_rise_i (sclk_rise),
    .sclk_fall_i (sclk_fall),
    .frame_rst_i (frame_rst),
    .sdo_o       (sdo_o),
    .oe_o        (sdo_oe_o),
    .cnt_o       (bit_cnt)
  );
endmodule

// File: rtl/sdo_port_chk.sv
module sdo_port_chk #(
  parameter int unsigned FRAME_W = 16,
  localparam int unsigned CNT_W  = $clog2(FRAME_W) + 1
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             sclk_lvl_i,
  input logic             sclk_rise_i,
  input logic             sclk_fall_i,
  input logic             cnv_fall_i,
  input logic [CNT_W-1:0] cnt_i,
  input logic             sdo_i,
  input logic             oe_i
);
  p_rise_enables_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(oe_i) |-> $past(sclk_rise_i));

  p_data_on_fall_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (oe_i && $past(oe_i) && !$stable(sdo_i)) |-> $past(sclk_fall_i));

  p_hold_on_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sclk_fall_i && !cnv_fall_i && oe_i && cnt_i == CNT_W'(FRAME_W - 1))
      |=> (oe_i && $stable(sdo_i)));

  p_release_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(oe_i) |-> ($past(cnv_fall_i && !sclk_lvl_i) || cnt_i == CNT_W'(FRAME_W)));

  p_cnv_reset_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnv_fall_i && !sclk_lvl_i) |=> (!oe_i && cnt_i == '0));

  p_cnv_ignored_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnv_fall_i && sclk_lvl_i) |=> ($stable(cnt_i) && $stable(oe_i)));
endmodule

bind sdo_port sdo_port_chk #(.FRAME_W(FRAME_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .sclk_lvl_i  (sclk_lvl),
  .sclk_rise_i (sclk_rise),
  .sclk_fall_i (sclk_fall),
  .cnv_fall_i  (cnv_fall),
  .cnt_i       (bit_cnt),
  .sdo_i       (sdo_o),
  .oe_i        (sdo_oe_o)
);

// File: tb/sim_sdo_port.sv
module sim_sdo_port;
  localparam int unsigned HOLD = 4;
  localparam int NVEC = 5;
  // {result, expected frame}
  localparam logic [27:0] VEC [NVEC] = '{
    {12'hA5C, 16'h0A5C}, {12'hFFF, 16'h0FFF}, {12'h000, 16'h0000},
    {12'h801, 16'h0801}, {12'h3C7, 16'h03C7}
  };

  logic clk = 1'b0, rst_ni = 1'b0, sclk = 1'b0, cnv = 1'b0, load = 1'b0;
  logic [11:0] res = '0;
  logic sdo, oe;
  int n_chk = 0, n_fail = 0;

  always #4 clk = ~clk;

  sdo_port #(.HOLD_CYCLES(HOLD)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .sclk_i(sclk), .cnv_i(cnv),
    .load_i(load), .result_i(res), .sdo_o(sdo), .sdo_oe_o(oe)
  );

  task automatic chk(string req, logic [1:0] act, logic [1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual oe/sdo=%b expected %b", req, act, exp);
    end
  endtask

  task automatic settle();
    repeat (4) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic sclk_set(logic v);
    sclk = v;
    settle();
  endtask

  task automatic convst();
    cnv = 1'b1; settle();
    cnv = 1'b0; settle();
  endtask

  task automatic load_res(logic [11:0] r);
    res = r; load = 1'b1;
    @(negedge clk);
    load = 1'b0;
  endtask

  task automatic read_frame(logic [15:0] f);
    sclk_set(1'b1);
    chk("R3 first rise", {oe, sdo}, {1'b1, f[15]});
    for (int k = 1; k <= 16; k++) begin
      sclk_set(1'b0);
      if (k < 16) begin
        chk(k == 15 ? "R5 lsb" : "R2 bit", {oe, sdo}, {1'b1, f[15-k]});
        if (k == 8) begin
          repeat (40) @(negedge clk);
          chk("R10 pause", {oe, sdo}, {1'b1, f[7]});
        end
        sclk_set(1'b1);
        chk("R4 rise", {oe, sdo}, {1'b1, f[15-k]});
      end else begin
        chk("R6 hold", {oe, sdo}, {1'b1, f[0]});
        repeat (HOLD) @(negedge clk);
        chk("R6 release", {oe, sdo}, 2'b00);
      end
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 in reset", {oe, sdo}, 2'b00);
    rst_ni = 1'b1;
    repeat (10) @(negedge clk);
    chk("R1 after reset", {oe, sdo}, 2'b00);

    for (int i = 0; i < NVEC; i++) begin
      load_res(VEC[i][27:16]);
      convst();
      chk("R8 reset off", {oe, sdo}, 2'b00);
      read_frame(VEC[i][15:0]);
    end

    // R7 / R12: wrap past frame end and counter overflow
    begin
      logic [15:0] f;
      f = 16'h0A5C;
      load_res(12'hA5C);
      convst();
      read_frame(f);
      for (int k = 16; k < 36; k++) begin
        sclk_set(1'b1);
        chk("R7 rise", {oe, sdo}, {1'b1, f[15 - (k % 16)]});
        sclk_set(1'b0);
        chk(k == 31 ? "R12 wrap" : "R7 fall", {oe, sdo}, {1'b1, f[15 - ((k + 1) % 16)]});
      end
      repeat (30) @(negedge clk);
      chk("R7 stays driven", {oe, sdo}, {1'b1, f[15 - 4]});
    end

    // R9: convert-start fall while serial clock high is ignored
    convst();
    sclk_set(1'b1);
    for (int k = 1; k <= 5; k++) begin
      sclk_set(1'b0);
      sclk_set(1'b1);
    end
    cnv = 1'b1; settle();
    cnv = 1'b0; settle();
    chk("R9 enable kept", {oe, sdo}, {1'b1, 1'b0});
    sclk_set(1'b0);
    chk("R9 position kept", {oe, sdo}, {1'b1, 1'b1});

    // R8: reset mid-frame with serial clock low
    convst();
    chk("R8 disabled", {oe, sdo}, 2'b00);
    sclk_set(1'b1);
    chk("R8 restart", {oe, sdo}, 2'b10);
    sclk_set(1'b0);
    sclk_set(1'b1);
    sclk_set(1'b0);
    sclk_set(1'b1);
    sclk_set(1'b0);
    sclk_set(1'b1);
    sclk_set(1'b0);
    chk("R8 msb after restart", {oe, sdo}, 2'b11);

    // R11: result change without load is ignored
    convst();
    load_res(12'h801);
    res = 12'h7FE;
    repeat (5) @(negedge clk);
    read_frame(16'h0801);
    load_res(12'h7FE);
    convst();
    read_frame(16'h07FE);

    finish_run();
  end
endmodule